// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block holds a small set of virtual-page to physical-frame mappings and answers translation requests in front of the cache hierarchy. Every request presents a virtual page number together with a read or write indication. All stored entries are compared with that page number at once. One cycle later the block reports one of three outcomes: a hit with the physical frame number, a protection fault, or a miss.

When a request misses, an outside handler walks the page tables and writes the mapping back through a refill port. The refill goes to the slot that already holds the same virtual page, if there is one. Otherwise it goes to the lowest empty slot. When every slot is in use, the slot is picked from a free-running LFSR. A single-cycle input drops all mappings at once.

Top module: `tlb_xlate`

## Requirements
- R1: After reset no request hits or faults; the first lookups of any page report a miss.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `look_req` high, and `rsp_hit`/`rsp_fault` are low whenever `rsp_valid` is low.
- R3: A request whose page is stored with the needed permission (read needs the read bit, write needs the write bit) gives `rsp_hit`=1, `rsp_fault`=0 and the stored frame on `rsp_pfn`.
- R4: A request whose page is not stored gives `rsp_hit`=0, `rsp_fault`=0 and `rsp_pfn`=0.
- R5: A request whose page is stored without the needed permission gives `rsp_fault`=1, `rsp_hit`=0 and `rsp_pfn`=0.
- R6: A refill in the same cycle as a request for the same page does not affect that request; a request in the following cycle sees the new mapping.
- R7: A refill of a page that is already stored replaces the frame and permissions in that slot. No other mapping is lost, and no two valid slots ever hold the same page.
- R8: While empty slots remain, a refill never removes a stored mapping, so up to 16 distinct pages can be held at the same time.
- R9: A refill of a new page into a full buffer removes exactly one existing mapping and stores the new one.
- R10: `inval_all` removes every mapping in one cycle and takes priority over a refill in the same cycle. A request in that same cycle still sees the old contents.
- R11: The eviction slot varies over time: a run of successive evictions does not always remove the mapping that was written last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| look_req | input | 1 | Translation request strobe |
| look_vpn | input | 20 | Virtual page number to translate |
| look_write | input | 1 | 1 = write access, 0 = read access |
| fill_en | input | 1 | Refill strobe |
| fill_vpn | input | 20 | Virtual page of the refill |
| fill_pfn | input | 20 | Physical frame of the refill |
| fill_rd | input | 1 | Read permission of the refill |
| fill_wr | input | 1 | Write permission of the refill |
| inval_all | input | 1 | Drop every mapping |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_fault | output | 1 | Page stored but access not permitted |
| rsp_pfn | output | 20 | Translated frame, zero unless hit |

## Verification
Requests cover all four combinations of read/write against read-only, write-only, read-write and no-permission pages. This separates a permission check done on the wrong bit from one that is missing altogether. A refill and a request for the same page are issued together to tell a registered lookup from one that forwards the refill. A refill of a page that is already stored, made into a full buffer, separates an update in place from a second insertion. A series of evictions, each checked by probing every old page, shows that exactly one mapping is lost each time and that the lost slot changes from one eviction to the next.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int VPN_W  = 20;
    parameter int PFN_W  = 20;
    parameter int LFSR_W = 8;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
        logic             rd;
        logic             wr;
    } tlb_entry_t;

    typedef struct packed {
        logic             hit;
        logic             fault;
        logic [PFN_W-1:0] pfn;
    } tlb_resp_t;

    // maximal-length 8-bit sequence, taps 8,6,5,4
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction
endpackage

// File: rtl/tlb_lfsr.sv
module tlb_lfsr
    import tlb_pkg::*;
#(
    parameter int OUT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    output logic [OUT_W-1:0] rnd
);
    logic [LFSR_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= LFSR_W'(1);
        else     state_q <= lfsr_step(state_q);
    end

    assign rnd = state_q[OUT_W-1:0];
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int N = 16
) (
    input  tlb_entry_t [N-1:0] tab,
    input  logic [N-1:0]       vld,
    input  logic [VPN_W-1:0]   key,
    output logic [N-1:0]       match
);
    for (genvar gi = 0; gi < N; gi++) begin : g_cmp
        assign match[gi] = vld[gi] && (tab[gi].vpn == key);
    end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     vld,
    input  logic [N-1:0]     same,
    input  logic [IDX_W-1:0] rnd,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] same_idx;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        same_idx = '0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (same[i]) same_idx = IDX_W'(i);
            if (!vld[i]) free_idx = IDX_W'(i);
        end
        if (|same)      idx = same_idx;
        else if (~&vld) idx = free_idx;
        else            idx = rnd;
    end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int N = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             look_req,
    input  logic [VPN_W-1:0] look_vpn,
    input  logic             look_write,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             fill_rd,
    input  logic             fill_wr,
    input  logic             inval_all,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_fault,
    output logic [PFN_W-1:0] rsp_pfn
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    tlb_entry_t [N-1:0] tab_q;
    logic [N-1:0]       vld_q;
    logic [N-1:0]       lk_match;
    logic [N-1:0]       fl_match;
    logic [IDX_W-1:0]   rnd;
    logic [IDX_W-1:0]   vic;
    tlb_entry_t         sel;
    logic               any;
    logic               allowed;
    tlb_resp_t          resp_d;
    tlb_resp_t          resp_q;
    logic               valid_q;

    tlb_cam #(.N(N)) u_look_cam (
        .tab(tab_q), .vld(vld_q), .key(look_vpn), .match(lk_match)
    );

    tlb_cam #(.N(N)) u_fill_cam (
        .tab(tab_q), .vld(vld_q), .key(fill_vpn), .match(fl_match)
    );

    tlb_lfsr #(.OUT_W(IDX_W)) u_lfsr (
        .clk(clk), .rst(rst), .rnd(rnd)
    );

    tlb_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
        .vld(vld_q), .same(fl_match), .rnd(rnd), .idx(vic)
    );

    // read side: at most one slot matches
    always_comb begin
        sel = '0;
        for (int i = 0; i < N; i++) begin
            if (lk_match[i]) sel = tab_q[i];
        end
        any          = |lk_match;
        allowed      = look_write ? sel.wr : sel.rd;
        resp_d.hit   = any && allowed;
        resp_d.fault = any && !allowed;
        resp_d.pfn   = (any && allowed) ? sel.pfn : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            resp_q  <= '0;
        end else begin
            valid_q <= look_req;
            resp_q  <= look_req ? resp_d : '0;
        end
    end

    // write side: flush wins over refill
    always_ff @(posedge clk) begin
        if (rst || inval_all) vld_q <= '0;
        else if (fill_en)     vld_q[vic] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst && !inval_all && fill_en) begin
            tab_q[vic] <= '{vpn: fill_vpn, pfn: fill_pfn, rd: fill_rd, wr: fill_wr};
        end
    end

    assign rsp_valid = valid_q;
    assign rsp_hit   = resp_q.hit;
    assign rsp_fault = resp_q.fault;
    assign rsp_pfn   = resp_q.pfn;
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk
    import tlb_pkg::*;
#(
    parameter int N = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               look_req,
    input logic               inval_all,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic               rsp_fault,
    input logic [PFN_W-1:0]   rsp_pfn,
    input logic [N-1:0]       vld_q,
    input tlb_entry_t [N-1:0] tab_q
);
    logic dup;

    always_comb begin
        dup = 1'b0;
        for (int i = 0; i < N; i++) begin
            for (int j = i + 1; j < N; j++) begin
                if (vld_q[i] && vld_q[j] && tab_q[i].vpn == tab_q[j].vpn) dup = 1'b1;
            end
        end
    end

    // R2
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        look_req |=> rsp_valid);

    // R2
    no_resp_without_req_chk: assert property (@(posedge clk) disable iff (rst)
        !look_req |=> !rsp_valid);

    // R2
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_hit && !rsp_fault));

    // R5
    hit_fault_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(rsp_hit && rsp_fault));

    // R4
    pfn_zero_unless_hit_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_hit |-> (rsp_pfn == '0));

    // R7
    no_duplicate_page_chk: assert property (@(posedge clk) disable iff (rst)
        !dup);

    // R10
    flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
        inval_all |=> (vld_q == '0));

    // R1
    reset_empties_chk: assert property (@(posedge clk)
        rst |=> (vld_q == '0));
endmodule

bind tlb_xlate tlb_xlate_chk #(.N(N)) u_chk (
    .clk(clk), .rst(rst), .look_req(look_req), .inval_all(inval_all),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .rsp_pfn(rsp_pfn), .vld_q(vld_q), .tab_q(tab_q)
);

// File: tb/tlb_xlate_bench.sv
`timescale 1ns/1ps
module tlb_xlate_bench;
    import tlb_pkg::*;

    localparam int NE = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             look_req = 1'b0;
    logic [VPN_W-1:0] look_vpn = '0;
    logic             look_write = 1'b0;
    logic             fill_en = 1'b0;
    logic [VPN_W-1:0] fill_vpn = '0;
    logic [PFN_W-1:0] fill_pfn = '0;
    logic             fill_rd = 1'b0;
    logic             fill_wr = 1'b0;
    logic             inval_all = 1'b0;
    logic             rsp_valid, rsp_hit, rsp_fault;
    logic [PFN_W-1:0] rsp_pfn;

    tlb_xlate #(.N(NE)) u_tlb_xlate (.*);

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic [PFN_W-1:0] pfn;
        bit               rd;
        bit               wr;
    } ment_t;
    ment_t mdb [logic [VPN_W-1:0]];

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one clock: drive, predict, advance to the next falling edge, compare
    task automatic cyc(bit req, logic [VPN_W-1:0] v, bit wr, bit fe,
                       logic [VPN_W-1:0] fv, logic [PFN_W-1:0] fp, bit frd, bit fwr,
                       bit fl, bit cmp, string tag);
        bit eh = 0, ef = 0;
        logic [PFN_W-1:0] ep = '0;
        look_req = req; look_vpn = v; look_write = wr;
        fill_en = fe; fill_vpn = fv; fill_pfn = fp; fill_rd = frd; fill_wr = fwr;
        inval_all = fl;
        if (req && mdb.exists(v)) begin
            bit ok = wr ? mdb[v].wr : mdb[v].rd;
            eh = ok; ef = !ok; ep = ok ? mdb[v].pfn : '0;
        end
        if (fl) mdb.delete();
        else if (fe) mdb[fv] = '{pfn: fp, rd: frd, wr: fwr};
        @(negedge clk);
        check("R2", 32'(rsp_valid), 32'(req));
        if (req && cmp) begin
            check(tag, 32'(rsp_hit), 32'(eh));
            check(tag, 32'(rsp_fault), 32'(ef));
            check(tag, 32'(rsp_pfn), 32'(ep));
        end
    endtask

    task automatic look(logic [VPN_W-1:0] v, bit wr, string tag);
        cyc(1, v, wr, 0, '0, '0, 0, 0, 0, 1, tag);
    endtask

    task automatic fill(logic [VPN_W-1:0] v, logic [PFN_W-1:0] p, bit rd, bit wr, string tag);
        cyc(0, '0, 0, 1, v, p, rd, wr, 0, 1, tag);
    endtask

    task automatic idle();
        cyc(0, '0, 0, 0, '0, '0, 0, 0, 0, 1, "R2");
    endtask

    task automatic probe_all(string tag);
        logic [VPN_W-1:0] q[$];
        foreach (mdb[k]) q.push_back(k);
        foreach (q[i]) look(q[i], 0, tag);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [VPN_W-1:0] q[$];
        logic [VPN_W-1:0] prev_new, gone, nv;
        int miss, same_cnt;

        repeat (3) @(negedge clk);
        check("R1", 32'(rsp_valid), 0);
        check("R1", 32'(rsp_hit), 0);
        rst = 1'b0;

        // R1 / R4: empty after reset
        look(20'h00000, 0, "R1");
        look(20'h00005, 1, "R4");
        idle();

        // R3 / R5: permission matrix
        fill(20'h00010, 20'hA0010, 1, 1, "R3");
        fill(20'h00020, 20'hA0020, 1, 0, "R3");
        fill(20'h00030, 20'hA0030, 0, 1, "R5");
        fill(20'h00040, 20'hA0040, 0, 0, "R5");
        look(20'h00010, 0, "R3");
        look(20'h00010, 1, "R3");
        look(20'h00020, 0, "R3");
        look(20'h00020, 1, "R5");
        look(20'h00030, 0, "R5");
        look(20'h00030, 1, "R3");
        look(20'h00040, 0, "R5");
        look(20'h00040, 1, "R5");
        look(20'h00011, 0, "R4");

        // R6: refill and request together, then after
        cyc(1, 20'h00050, 0, 1, 20'h00050, 20'hA0050, 1, 1, 0, 0, "R6");
        check("R6", 32'(rsp_hit), 0);
        look(20'h00050, 0, "R6");

        // R7: overwrite in place
        fill(20'h00020, 20'hC0020, 1, 1, "R7");
        look(20'h00020, 1, "R7");

        // R8: fill up to capacity, nothing lost
        for (int k = 0; k < NE - 5; k++) fill(20'h00200 + 20'(k), 20'hD0000 + 20'(k), 1, 1, "R8");
        check("R8", 32'(mdb.num()), NE);
        probe_all("R8");

        // R7: overwrite while full keeps everything
        fill(20'h00010, 20'hE0010, 1, 0, "R7");
        probe_all("R7");
        look(20'h00010, 1, "R7");

        // R9 / R11: evictions in a full buffer
        prev_new = '0;
        same_cnt = 0;
        for (int k = 0; k < 8; k++) begin
            nv = 20'h00100 + 20'(k);
            cyc(0, '0, 0, 1, nv, 20'hB0000 + 20'(k), 1, 1, 0, 0, "R9");
            q.delete();
            foreach (mdb[key]) if (key != nv) q.push_back(key);
            miss = 0;
            gone = '0;
            foreach (q[i]) begin
                cyc(1, q[i], 0, 0, '0, '0, 0, 0, 0, 0, "R9");
                if (!rsp_hit && !rsp_fault) begin
                    miss++;
                    gone = q[i];
                    mdb.delete(q[i]);
                end
            end
            check("R9", 32'(miss), 1);
            look(nv, 0, "R9");
            if (k > 0 && gone == prev_new) same_cnt++;
            prev_new = nv;
        end
        check("R11", 32'(same_cnt < 7), 1);
        probe_all("R9");

        // R10: flush with request and refill in the same cycle
        q.delete();
        foreach (mdb[key]) q.push_back(key);
        cyc(1, q[0], 0, 1, 20'h00777, 20'hF0777, 1, 1, 1, 1, "R10");
        check("R10", 32'(rsp_hit | rsp_fault), 1);
        look(q[0], 0, "R10");
        look(20'h00777, 0, "R10");
        look(q[1], 1, "R10");
        idle();

        // restart after flush
        fill(20'h00007, 20'h12345, 1, 0, "R3");
        look(20'h00007, 0, "R3");
        look(20'h00007, 1, "R5");
        idle();

        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule